// File: doc/BRIEF.md
# Watchdog Counter with Reset Control

This block is an 8-bit up-counter that supervises software. It counts prescaled ticks and has two modes, chosen by an input pin. In watchdog mode, a wrap of the counter from 0xFF to 0x00 marks a lapse. The lapse sets a sticky flag and clears the watchdog's own state. If software has enabled it, the lapse also raises a fixed-length internal reset request for the rest of the chip. In interval mode, each wrap gives a one-cycle interrupt pulse instead, and the counter keeps running.

Software reaches two byte registers through a simple read/write port: the counter itself, and a reset control/status byte. The flag in the status byte has a guarded clear. Software must first read the byte while the flag is set, and then write 0 to the flag bit. The control/status byte is reset only by the external reset pin. It keeps its contents through the internal reset that the block raises itself.

Top module: `wdog_rstctl`

## Requirements
- R1: The counter increments by one on each clock edge where both `cntEn` and `tickIn` are high, and holds otherwise. Going from 0xFF to 0x00 is an overflow.
- R2: Writing to address 0 loads `wrData` into the counter, and this load wins over a tick in the same cycle. Reading address 0 returns the counter; reading address 1 returns the control/status byte.
- R3: Bit 7 of the control/status byte is the lapse flag. It is set by an overflow while `wdMode` is 1. It is never set by an overflow while `wdMode` is 0.
- R4: The flag is cleared only by a write to address 1 with bit 7 = 0 that follows a read of address 1 which returned bit 7 = 1. A new set between the read and the write cancels that read. A write with bit 7 = 1 leaves the flag unchanged. An overflow in the same cycle as the clearing write leaves the flag set.
- R5: When bit 6 (reset enable) is 1, a watchdog-mode overflow drives `rstReq` high for exactly 8 clocks, starting the cycle after the overflow edge.
- R6: After every watchdog-mode overflow, whatever the value of bit 6, the counter reads 0 and ignores ticks for 8 clocks, then resumes. When bit 6 is 0, `rstReq` stays low.
- R7: After `extRstN` the control/status byte reads 0x1F. Bits 4..0 always read 1. Bit 5 is written and read back. The byte keeps its value through the block's own reset request.
- R8: In interval mode, an overflow gives `irq` high for exactly one cycle, the cycle after the overflow edge. The counter continues from 0x00 without a hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| extRstN | input | 1 | External reset pin, active low, asynchronous |
| wdMode | input | 1 | 1 = watchdog mode, 0 = interval mode |
| cntEn | input | 1 | Counter enable |
| tickIn | input | 1 | Prescaled count tick |
| addr | input | 1 | Register select: 0 counter, 1 control/status |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (arms the flag clear) |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for the selected register |
| rstReq | output | 1 | Internal reset request pulse |
| irq | output | 1 | Interval interrupt pulse |

## Verification
If the arm state of the flag clear is wrong, the flag shows a wrong value on the read port on the very next read of address 1 after a write of 0. A hold counter that is off by one moves the first nonzero counter reading, and the falling edge of `rstReq`, by one clock. The bench checks both at the exact cycle. Sweeps over loaded values and tick counts compare the counter with (load + ticks) mod 256, which exposes any error in increment or wrap within a few clocks.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int CNT_W = 8;
  localparam int PULSE_LEN = 8;

  // Strobes from control to datapath
  typedef struct packed {
    logic hold;  // internal clear in progress
    logic load;  // software load of the counter
  } dpCtl_t;
endpackage

// File: rtl/wdog_dp.sv
module wdog_dp
  import wdog_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  dpCtl_t       ctl,
  input  logic [W-1:0] loadVal,
  input  logic         cntEn,
  input  logic         tickIn,
  output logic [W-1:0] cnt,
  output logic         ovf
);
  localparam logic [W-1:0] TOP = '1;

  logic step;

  assign step = cntEn & tickIn & ~ctl.hold & ~ctl.load;
  assign ovf  = step & (cnt == TOP);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         cnt <= '0;
    else if (ctl.hold) cnt <= '0;
    else if (ctl.load) cnt <= loadVal;
    else if (step)     cnt <= cnt + 1'b1;
  end

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ovf |=> (cnt == '0)); // R1
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && !ctl.hold) |=> (cnt == $past(loadVal))); // R2
  AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    ctl.hold |=> (cnt == '0)); // R6
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int W = CNT_W,
  parameter int PLEN = PULSE_LEN
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         wdMode,
  input  logic         ovf,
  input  logic         addr,
  input  logic         wrEn,
  input  logic         rdEn,
  input  logic [W-1:0] wrData,
  input  logic [W-1:0] cnt,
  output dpCtl_t       ctl,
  output logic [W-1:0] rdData,
  output logic         rstReq,
  output logic         irq
);
  localparam int FLAG_BIT  = 7;
  localparam int RSTEN_BIT = 6;
  localparam int SPARE_BIT = 5;
  localparam int PCW = $clog2(PLEN + 1);
  localparam logic [7:0] CSR_INIT = 8'h1F;

  logic           flag, armed, rstEn, spare, rstFire;
  logic [PCW-1:0] pulseCnt;
  logic           busy, setNow, clrNow, csrWr, csrRd;
  logic [7:0]     csrVal;

  assign busy   = (pulseCnt != '0);
  assign setNow = ovf & wdMode;
  assign csrWr  = wrEn & addr;
  assign csrRd  = rdEn & addr;
  assign clrNow = csrWr & ~wrData[FLAG_BIT] & armed & ~setNow;

  assign ctl.hold = busy;
  assign ctl.load = wrEn & ~addr;

  always_comb begin
    csrVal = CSR_INIT;
    csrVal[FLAG_BIT]  = flag;
    csrVal[RSTEN_BIT] = rstEn;
    csrVal[SPARE_BIT] = spare;
  end

  assign rdData = addr ? csrVal : cnt;
  assign rstReq = busy & rstFire;

  // Control/status byte: external reset only
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flag  <= CSR_INIT[FLAG_BIT];
      rstEn <= CSR_INIT[RSTEN_BIT];
      spare <= CSR_INIT[SPARE_BIT];
      armed <= 1'b0;
    end else begin
      if (setNow)      flag <= 1'b1;
      else if (clrNow) flag <= 1'b0;

      if (setNow || clrNow)   armed <= 1'b0;
      else if (csrRd && flag) armed <= 1'b1;

      if (csrWr) begin
        rstEn <= wrData[RSTEN_BIT];
        spare <= wrData[SPARE_BIT];
      end
    end
  end

  // Internal clear pulse and interval interrupt
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseCnt <= '0;
      rstFire  <= 1'b0;
      irq      <= 1'b0;
    end else begin
      irq <= ovf & ~wdMode;
      if (setNow) begin
        pulseCnt <= PCW'(PLEN);
        rstFire  <= rstEn;
      end else if (busy) begin
        pulseCnt <= pulseCnt - 1'b1;
      end
    end
  end

  AST_FLAG_NOT_INTERVAL: assert property (@(posedge clk) disable iff (!rstN)
    (ovf && !wdMode && !flag) |=> !flag); // R3
  AST_FLAG_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (ovf && wdMode) |=> flag); // R4
  AST_RST_ON: assert property (@(posedge clk) disable iff (!rstN)
    (ovf && wdMode && rstEn) |=> rstReq); // R5
  AST_RST_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (ovf && wdMode && !rstEn) |=> !rstReq); // R6
  AST_IRQ_ON: assert property (@(posedge clk) disable iff (!rstN)
    (ovf && !wdMode) |=> irq); // R8
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq); // R8
  AST_RO_ONES: assert property (@(posedge clk) disable iff (!rstN)
    addr |-> (rdData[4:0] == 5'h1F)); // R7
endmodule

// File: rtl/wdog_rstctl.sv
module wdog_rstctl
  import wdog_pkg::*;
#(
  parameter int W = CNT_W,
  parameter int PLEN = PULSE_LEN
) (
  input  logic         clk,
  input  logic         extRstN,
  input  logic         wdMode,
  input  logic         cntEn,
  input  logic         tickIn,
  input  logic         addr,
  input  logic         wrEn,
  input  logic         rdEn,
  input  logic [W-1:0] wrData,
  output logic [W-1:0] rdData,
  output logic         rstReq,
  output logic         irq
);
  dpCtl_t       ctl;
  logic [W-1:0] cnt;
  logic         ovf;

  wdog_dp #(.W(W)) dp_i (
    .clk(clk), .rstN(extRstN), .ctl(ctl), .loadVal(wrData),
    .cntEn(cntEn), .tickIn(tickIn), .cnt(cnt), .ovf(ovf)
  );

  wdog_ctrl #(.W(W), .PLEN(PLEN)) ctrl_i (
    .clk(clk), .rstN(extRstN), .wdMode(wdMode), .ovf(ovf),
    .addr(addr), .wrEn(wrEn), .rdEn(rdEn), .wrData(wrData), .cnt(cnt),
    .ctl(ctl), .rdData(rdData), .rstReq(rstReq), .irq(irq)
  );
endmodule

// File: tb/wdog_rstctl_tb_top.sv
`timescale 1ns/1ps
module wdog_rstctl_tb_top;
  logic clk = 1'b0;
  logic extRstN = 1'b0;
  logic wdMode = 1'b0, cntEn = 1'b0, tickIn = 1'b0;
  logic addr = 1'b0, wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic rstReq, irq;
  int total = 0, bad = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  wdog_rstctl dut_i (
    .clk(clk), .extRstN(extRstN), .wdMode(wdMode), .cntEn(cntEn),
    .tickIn(tickIn), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .rstReq(rstReq), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic a, input logic [7:0] d);
    @(negedge clk); addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rdReg(input logic a, output logic [7:0] d);
    @(negedge clk); addr = a; rdEn = 1'b1; #0.5 d = rdData;
    @(negedge clk); rdEn = 1'b0;
  endtask

  task automatic runTicks(input int k);
    @(negedge clk); cntEn = 1'b1; tickIn = 1'b1;
    repeat (k) @(negedge clk);
    cntEn = 1'b0; tickIn = 1'b0;
  endtask

  // Watchdog overflow with ticks kept on; checks hold and reset pulse
  task automatic wdLapse(input logic expRst);
    wrReg(1'b0, 8'hFF);
    @(negedge clk); addr = 1'b0; cntEn = 1'b1; tickIn = 1'b1;
    @(negedge clk);
    chk("R5 rstReq after lapse", {7'd0, rstReq}, {7'd0, expRst});
    chk("R6 counter zero after lapse", rdData, 8'h00);
    for (int i = 1; i <= 8; i++) begin
      @(negedge clk);
      chk("R6 counter held", rdData, 8'h00);
      chk("R5 rstReq width", {7'd0, rstReq}, {7'd0, expRst && (i < 8)});
    end
    @(negedge clk);
    chk("R6 counter resumes", rdData, 8'h01);
    cntEn = 1'b0; tickIn = 1'b0;
  endtask

  initial begin
    #(4.0 * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    // R7 reset state
    chk("R7 reset rstReq", {7'd0, rstReq}, 8'h00);
    chk("R8 reset irq", {7'd0, irq}, 8'h00);
    rdReg(1'b1, r); chk("R7 csr reset", r, 8'h1F);
    @(negedge clk); extRstN = 1'b1;
    rdReg(1'b0, r); chk("R2 counter reset", r, 8'h00);

    // R1/R2 sweep in interval mode
    for (int v = 0; v < 256; v += 15) begin
      for (int k = 1; k <= 3; k++) begin
        wrReg(1'b0, 8'(v));
        runTicks(k);
        rdReg(1'b0, r);
        chk("R1 count sweep", r, 8'((v + k) % 256));
      end
    end
    // R1 no tick without enable
    wrReg(1'b0, 8'h33);
    @(negedge clk); tickIn = 1'b1; repeat (3) @(negedge clk); tickIn = 1'b0;
    @(negedge clk); cntEn = 1'b1; repeat (3) @(negedge clk); cntEn = 1'b0;
    rdReg(1'b0, r); chk("R1 hold without both", r, 8'h33);
    // R2 load beats tick
    @(negedge clk); cntEn = 1'b1; tickIn = 1'b1; addr = 1'b0; wrData = 8'h40; wrEn = 1'b1;
    @(negedge clk); cntEn = 1'b0; tickIn = 1'b0; wrEn = 1'b0;
    rdReg(1'b0, r); chk("R2 load priority", r, 8'h40);

    // R8 interval overflow
    wrReg(1'b0, 8'hFE);
    runTicks(1);
    chk("R8 no irq before wrap", {7'd0, irq}, 8'h00);
    @(negedge clk); addr = 1'b0; cntEn = 1'b1; tickIn = 1'b1;
    @(negedge clk); cntEn = 1'b0; tickIn = 1'b0;
    chk("R8 irq pulse", {7'd0, irq}, 8'h01);
    chk("R8 counter wrapped", rdData, 8'h00);
    chk("R8 no rstReq", {7'd0, rstReq}, 8'h00);
    @(negedge clk);
    chk("R8 irq single", {7'd0, irq}, 8'h00);
    runTicks(2);
    rdReg(1'b0, r); chk("R8 no hold in interval", r, 8'h02);
    rdReg(1'b1, r); chk("R3 no flag in interval", r, 8'h1F);

    // R3/R6 watchdog lapse without reset enable
    wdMode = 1'b1;
    wdLapse(1'b0);
    rdReg(1'b1, r); chk("R3 flag set", r, 8'h9F);
    // R4 guarded clear (previous read armed it)
    wrReg(1'b1, 8'h80);
    rdReg(1'b1, r); chk("R4 write one keeps flag", r, 8'h9F);
    wrReg(1'b1, 8'h00);
    rdReg(1'b1, r); chk("R4 armed clear", r, 8'h1F);
    // R7 bit 5 writable
    wrReg(1'b1, 8'h20);
    rdReg(1'b1, r); chk("R7 bit5 writable", r, 8'h3F);

    // R5 with reset enable
    wrReg(1'b1, 8'h40);
    wdLapse(1'b1);
    rdReg(1'b1, r); chk("R7 csr survives internal reset", r, 8'hDF);
    // R4 a new set cancels the arming read
    wdLapse(1'b1);
    wrReg(1'b1, 8'h40);
    rdReg(1'b1, r); chk("R4 set cancels arm", r, 8'hDF);
    // R4 unread write of zero does nothing: re-arm then overflow coinciding with clear
    wrReg(1'b0, 8'hFF);
    @(negedge clk); cntEn = 1'b1; tickIn = 1'b1; addr = 1'b1; wrData = 8'h40; wrEn = 1'b1;
    @(negedge clk); cntEn = 1'b0; tickIn = 1'b0; wrEn = 1'b0;
    repeat (10) @(negedge clk);
    rdReg(1'b1, r); chk("R4 overflow beats clear", r, 8'hDF);
    wrReg(1'b1, 8'h40);
    rdReg(1'b1, r); chk("R4 clear after fresh read", r, 8'h5F);

    // R7 external reset restores
    @(negedge clk); extRstN = 1'b0;
    @(negedge clk);
    rdReg(1'b1, r); chk("R7 csr after pin reset", r, 8'h1F);
    @(negedge clk); extRstN = 1'b1;

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule